// File: doc/BRIEF.md
# Pending Interrupt Wake Messenger

This block sits in the power-management logic of a processor core. When the platform asserts the stop-clock request, the core answers with a stop-grant message and then waits in a low-power state. An interrupt that is already pending at that moment would normally wait until the stop-clock request is withdrawn. This block prevents that wait. It sends a wake notification that tells the platform to release the core early.

A software-writable configuration register selects one of two notification methods.

- **I/O-cycle method.** The block checks for a pending interrupt at the end of every I/O instruction. If one is pending while stop-clock is asserted, the block issues a single byte-sized I/O access to a programmed port. Platform firmware uses that access to raise a system-management interrupt. The access goes out on a valid/ready request channel.
- **Link-message method.** The block checks for a pending interrupt when the core enters stop-grant. If one is pending, the block sends an interrupt-pending link message first and delays the stop-grant message by one cycle.

A suppression bit blocks the I/O-cycle method. The system-management handler sets it so that its own I/O does not trigger a new wake.

Top module: `pend_wake_msgr`

## Requirements
- R1: After reset every output is low and the configuration register holds zero. With that zero setting a qualifying I/O check produces a write of data 0x00 to port 0x0000.
- R2: The configuration word is laid out as follows: bits [15:0] port address, bits [23:16] data byte, bit 24 suppress, bit 25 method (1 = link message), bit 26 read select. With method 0 and suppress 0, `io_end` high in the same cycle as `stpclk_req`, `irq_pend` and an armed state raises `io_req_valid` on the following cycle. The request carries the programmed address and data and has `io_req_write` = 1 when bit 26 is 0 (example: word 0x003300B0 gives a write of 0x33 to port 0xB0).
- R3: When bit 26 is 1, the I/O wake request is a read (`io_req_write` = 0) of the programmed port, and `io_req_data` is driven to 0x00.
- R4: No I/O wake request is raised if any of `io_end`, `stpclk_req` or `irq_pend` is low in the checking cycle.
- R5: While bit 24 is set, `io_end` raises no I/O wake request and does not consume the armed state. Clearing the bit lets the next qualifying `io_end` in the same stop-clock assertion raise the request.
- R6: Once raised, `io_req_valid`, `io_req_addr`, `io_req_data` and `io_req_write` stay unchanged until a cycle with `io_req_ready` high. This holds even when the register is rewritten meanwhile. `io_req_valid` is low in the cycle after acceptance.
- R7: With method 1, `grant_entry` in a cycle where `stpclk_req`, `irq_pend` and the armed state hold produces a one-cycle `link_pend_msg` on the next cycle and a one-cycle `grant_msg` on the cycle after that. In this mode `io_end` raises no I/O request.
- R8: A `grant_entry` that raises no link message produces a one-cycle `grant_msg` on the next cycle and no `link_pend_msg`, in either method.
- R9: At most one wake notification, on either method, is issued per stop-clock assertion. The block re-arms after `stpclk_req` has been low for at least one cycle.
- R10: Bit 24 has no effect on the link-message method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 32 | Configuration word written when `cfg_we` is high |
| stpclk_req | input | 1 | Stop-clock request from the platform |
| irq_pend | input | 1 | An interrupt is pending at the core |
| io_end | input | 1 | Strobe marking the end of an I/O instruction |
| grant_entry | input | 1 | Strobe marking entry to the stop-grant state |
| io_req_ready | input | 1 | The I/O bus accepts the wake request |
| io_req_valid | output | 1 | An I/O wake request is outstanding |
| io_req_addr | output | 16 | I/O port of the wake access |
| io_req_data | output | 8 | Byte written by the wake access (0 for reads) |
| io_req_write | output | 1 | 1 = write access, 0 = read access |
| link_pend_msg | output | 1 | One-cycle interrupt-pending link message request |
| grant_msg | output | 1 | One-cycle stop-grant message request |

## Verification
The I/O-cycle method is tried with a vector table that turns off each qualifying input in turn. This separates a correct AND of the conditions from one that ignores an input. The table also covers write, read, suppressed and link-mode register words, so that each register field is shown to steer the access. Directed sequences cover the following:

- Holding `io_req_ready` low while the register is rewritten, which exposes a request that follows the register instead of a latched copy.
- Repeating checks inside one stop-clock assertion and after a release, which tells a single-shot arm from a level-sensitive trigger.
- Comparing the grant timing with and without a pending interrupt in both methods, which shows whether the stop-grant message is delayed only when a link message goes ahead of it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int PW_ADDR_W  = 16;
  localparam int PW_DATA_W  = 8;
  localparam int PW_WORD_W  = 32;
  localparam int PW_DATA_LO = PW_ADDR_W;
  localparam int PW_DIS_BIT = PW_DATA_LO + PW_DATA_W;
  localparam int PW_LNK_BIT = PW_DIS_BIT + 1;
  localparam int PW_RD_BIT  = PW_LNK_BIT + 1;

  typedef struct packed {
    logic                 rd_sel;
    logic                 link_sel;
    logic                 io_dis;
    logic [PW_DATA_W-1:0] data;
    logic [PW_ADDR_W-1:0] addr;
  } pw_cfg_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_t;

  function automatic pw_cfg_t decode_cfg(input logic [PW_WORD_W-1:0] w);
    pw_cfg_t c;
    c.addr     = w[PW_ADDR_W-1:0];
    c.data     = w[PW_DIS_BIT-1:PW_DATA_LO];
    c.io_dis   = w[PW_DIS_BIT];
    c.link_sel = w[PW_LNK_BIT];
    c.rd_sel   = w[PW_RD_BIT];
    return c;
  endfunction

  function automatic logic wake_due(input logic stop, input logic pend,
                                    input logic armed);
    return stop & pend & armed;
  endfunction

  function automatic logic [PW_DATA_W-1:0] io_byte(input pw_cfg_t c);
    return c.rd_sel ? '0 : c.data;
  endfunction

endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [PW_WORD_W-1:0] wdata,
  output pw_cfg_t              cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg <= decode_cfg(wdata);
    end
  end

endmodule

// File: rtl/pwm_arm_ctl.sv
module pwm_arm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic fire,
  output logic armed
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (!stop) begin
      armed <= 1'b1;
    end else if (fire) begin
      armed <= 1'b0;
    end
  end

  // R9: a wake can only be fired while armed
  p_fire_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> armed);

  // R9: a spent arm stays spent for the rest of the stop-clock assertion
  p_stay_spent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && stop) |=> !armed);

endmodule

// File: rtl/pwm_io_path.sv
module pwm_io_path
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pw_cfg_t              cfg,
  input  logic                 check,
  input  logic                 stop,
  input  logic                 pend,
  input  logic                 armed,
  input  logic                 ready,
  output logic                 valid,
  output logic [PW_ADDR_W-1:0] addr,
  output logic [PW_DATA_W-1:0] data,
  output logic                 write,
  output logic                 fire
);

  logic qualify;

  assign qualify = check & !cfg.link_sel & !cfg.io_dis;
  assign fire    = qualify & wake_due(stop, pend, armed) & !valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
      write <= 1'b0;
    end else if (fire) begin
      valid <= 1'b1;
      addr  <= cfg.addr;
      data  <= io_byte(cfg);
      write <= !cfg.rd_sel;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R6: the request and its payload hold until accepted
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data) && $stable(write)));

  // R6: an accepted request drops on the next cycle
  p_drop_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !valid);

  // R5: a new request never appears while suppressed
  p_no_io_when_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && cfg.io_dis && !fire) |=> !valid);

  // R3: a read request carries no data byte
  p_read_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !write) |-> (data == '0));

endmodule

// File: rtl/pwm_grant_seq.sv
module pwm_grant_seq
  import pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_sel,
  input  logic entry,
  input  logic stop,
  input  logic pend,
  input  logic armed,
  output logic link_msg,
  output logic grant,
  output logic fire
);

  seq_state_t state;
  logic       idle_entry;

  assign idle_entry = (state == SEQ_IDLE) & entry;
  assign fire       = idle_entry & link_sel & wake_due(stop, pend, armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      link_msg <= 1'b0;
      grant    <= 1'b0;
    end else begin
      link_msg <= 1'b0;
      grant    <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (fire) begin
            link_msg <= 1'b1;
            state    <= SEQ_HOLD;
          end else if (entry) begin
            grant <= 1'b1;
          end
        end
        SEQ_HOLD: begin
          grant <= 1'b1;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7: the stop-grant message follows the link message on the next cycle
  p_grant_after_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_msg |=> (grant && !link_msg));

  // R7: the two messages never go out together
  p_msgs_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_msg && grant));

  // R8: a plain entry is answered one cycle later
  p_plain_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_entry && !fire) |=> grant);

endmodule

// File: rtl/pend_wake_msgr.sv
module pend_wake_msgr
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [PW_WORD_W-1:0] cfg_wdata,
  input  logic                 stpclk_req,
  input  logic                 irq_pend,
  input  logic                 io_end,
  input  logic                 grant_entry,
  input  logic                 io_req_ready,
  output logic                 io_req_valid,
  output logic [PW_ADDR_W-1:0] io_req_addr,
  output logic [PW_DATA_W-1:0] io_req_data,
  output logic                 io_req_write,
  output logic                 link_pend_msg,
  output logic                 grant_msg
);

  pw_cfg_t cfg;
  logic    armed;
  logic    io_fire;
  logic    link_fire;
  logic    any_fire;

  assign any_fire = io_fire | link_fire;

  pwm_cfg_reg i_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  pwm_arm_ctl i_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .stop  (stpclk_req),
    .fire  (any_fire),
    .armed (armed)
  );

  pwm_io_path i_io (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (cfg),
    .check (io_end),
    .stop  (stpclk_req),
    .pend  (irq_pend),
    .armed (armed),
    .ready (io_req_ready),
    .valid (io_req_valid),
    .addr  (io_req_addr),
    .data  (io_req_data),
    .write (io_req_write),
    .fire  (io_fire)
  );

  pwm_grant_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_sel (cfg.link_sel),
    .entry    (grant_entry),
    .stop     (stpclk_req),
    .pend     (irq_pend),
    .armed    (armed),
    .link_msg (link_pend_msg),
    .grant    (grant_msg),
    .fire     (link_fire)
  );

  // R9: the two wake paths never fire in the same cycle
  p_single_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_fire && link_fire));

  // R2: a new I/O request stems from a qualifying end-of-I/O check
  p_io_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_req_valid && !(io_end && stpclk_req && irq_pend)) |=> !io_req_valid);

  // R7: in link mode no I/O request is raised
  p_link_no_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_req_valid && cfg.link_sel) |=> !io_req_valid);

endmodule

// File: tb/test_pend_wake_msgr.sv
module test_pend_wake_msgr;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        stpclk_req, irq_pend, io_end, grant_entry, io_req_ready;
  logic        io_req_valid, io_req_write, link_pend_msg, grant_msg;
  logic [15:0] io_req_addr;
  logic [7:0]  io_req_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pend_wake_msgr i_pend_wake_msgr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stpclk_req(stpclk_req), .irq_pend(irq_pend), .io_end(io_end),
    .grant_entry(grant_entry), .io_req_ready(io_req_ready),
    .io_req_valid(io_req_valid), .io_req_addr(io_req_addr),
    .io_req_data(io_req_data), .io_req_write(io_req_write),
    .link_pend_msg(link_pend_msg), .grant_msg(grant_msg)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic        stop;
    logic        pend;
    logic        iend;
    logic        exp_v;
    logic [15:0] exp_a;
    logic [7:0]  exp_d;
    logic        exp_w;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h003300B0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h00B0, 8'h33, 1'b1}, // R2
    '{32'h043300B0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h00B0, 8'h00, 1'b0}, // R3
    '{32'h0055ABCD, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0}, // R4
    '{32'h0055ABCD, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0}, // R4
    '{32'h0055ABCD, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R4
    '{32'h0155ABCD, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0}, // R5
    '{32'h0255ABCD, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0}, // R7
    '{32'h0012FFFF, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 8'h12, 1'b1}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wcfg(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rearm();
    stpclk_req = 1'b0;
    tick();
  endtask

  task automatic pulse_io();
    io_end = 1'b1;
    tick();
    io_end = 1'b0;
  endtask

  task automatic accept();
    io_req_ready = 1'b1;
    tick();
    io_req_ready = 1'b0;
  endtask

  function automatic logic [31:0] req_word();
    return {7'd0, io_req_write, io_req_data, io_req_addr};
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; stpclk_req = 1'b0;
    irq_pend = 1'b0; io_end = 1'b0; grant_entry = 1'b0; io_req_ready = 1'b0;
    @(negedge clk);
    tick(); tick();
    // R1: outputs low during and after reset
    chk("R1 outputs in reset",
        {28'd0, io_req_valid, link_pend_msg, grant_msg, io_req_write}, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 outputs after reset",
        {28'd0, io_req_valid, link_pend_msg, grant_msg, io_req_write}, 32'd0);
    // R1: cleared register means a write of 0x00 to port 0
    stpclk_req = 1'b1; irq_pend = 1'b1;
    pulse_io();
    chk("R1 default valid", {31'd0, io_req_valid}, 32'd1);
    chk("R1 default payload", req_word(), {7'd0, 1'b1, 8'h00, 16'h0000});
    accept();

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      rearm();
      wcfg(VECS[i].cfg);
      stpclk_req = VECS[i].stop; irq_pend = VECS[i].pend; io_end = VECS[i].iend;
      tick();
      io_end = 1'b0;
      chk($sformatf("R2/R3/R4/R5/R7 vec%0d valid", i), {31'd0, io_req_valid},
          {31'd0, VECS[i].exp_v});
      if (VECS[i].exp_v) begin
        chk($sformatf("R2/R3 vec%0d payload", i), req_word(),
            {7'd0, VECS[i].exp_w, VECS[i].exp_d, VECS[i].exp_a});
        accept();
        chk($sformatf("R6 vec%0d drop", i), {31'd0, io_req_valid}, 32'd0);
      end
    end

    // R6: held stable through stalls and register rewrites
    rearm();
    wcfg(32'h003300B0);
    stpclk_req = 1'b1; irq_pend = 1'b1;
    pulse_io();
    cfg_we = 1'b1; cfg_wdata = 32'h04AA1234;
    tick();
    cfg_we = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R6 stalled valid", {31'd0, io_req_valid}, 32'd1);
      chk("R6 stalled payload", req_word(), {7'd0, 1'b1, 8'h33, 16'h00B0});
      tick();
    end
    accept();
    chk("R6 dropped after accept", {31'd0, io_req_valid}, 32'd0);

    // R9: no second wake within one assertion, re-arm after release
    wcfg(32'h003300B0);
    pulse_io();
    chk("R9 no second io wake", {31'd0, io_req_valid}, 32'd0);
    rearm();
    stpclk_req = 1'b1;
    pulse_io();
    chk("R9 re-armed io wake", {31'd0, io_req_valid}, 32'd1);
    accept();

    // R5: suppression does not consume the arm
    rearm();
    wcfg(32'h01330080);
    stpclk_req = 1'b1;
    pulse_io();
    chk("R5 suppressed", {31'd0, io_req_valid}, 32'd0);
    wcfg(32'h00330080);
    pulse_io();
    chk("R5 after unsuppress valid", {31'd0, io_req_valid}, 32'd1);
    chk("R5 after unsuppress payload", req_word(), {7'd0, 1'b1, 8'h33, 16'h0080});
    accept();

    // R7: link message then delayed grant
    rearm();
    wcfg(32'h02000000);
    stpclk_req = 1'b1; irq_pend = 1'b1;
    grant_entry = 1'b1;
    tick();
    grant_entry = 1'b0;
    chk("R7 link msg first", {30'd0, link_pend_msg, grant_msg}, 32'b10);
    tick();
    chk("R7 grant follows", {30'd0, link_pend_msg, grant_msg}, 32'b01);
    tick();
    chk("R7 both low after", {30'd0, link_pend_msg, grant_msg}, 32'b00);

    // R9: second entry in same assertion gets only a grant
    grant_entry = 1'b1;
    tick();
    grant_entry = 1'b0;
    chk("R9 link spent grant only", {30'd0, link_pend_msg, grant_msg}, 32'b01);
    tick();

    // R8: link mode without pending interrupt
    rearm();
    stpclk_req = 1'b1; irq_pend = 1'b0;
    grant_entry = 1'b1;
    tick();
    grant_entry = 1'b0;
    chk("R8 link mode no pend", {30'd0, link_pend_msg, grant_msg}, 32'b01);
    tick();
    chk("R8 link mode pulse ends", {30'd0, link_pend_msg, grant_msg}, 32'b00);

    // R8: I/O mode entry gives plain grant even with pending interrupt
    rearm();
    wcfg(32'h003300B0);
    stpclk_req = 1'b1; irq_pend = 1'b1;
    grant_entry = 1'b1;
    tick();
    grant_entry = 1'b0;
    chk("R8 io mode grant", {30'd0, link_pend_msg, grant_msg}, 32'b01);
    tick();
    chk("R8 io mode no io request", {31'd0, io_req_valid}, 32'd0);

    // R10: suppress bit ignored by link method
    rearm();
    wcfg(32'h03000000);
    stpclk_req = 1'b1;
    grant_entry = 1'b1;
    tick();
    grant_entry = 1'b0;
    chk("R10 link msg despite suppress", {30'd0, link_pend_msg, grant_msg}, 32'b10);
    tick();
    chk("R10 grant follows", {30'd0, link_pend_msg, grant_msg}, 32'b01);
    tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule